// File: doc/BRIEF.md
# Four-Accumulator Multiply-Accumulate Unit

This block multiplies two 32-bit operands and adds the product to, or subtracts it from, one of four 48-bit accumulators, all in a single clock cycle. Each accumulator is a 32-bit low word plus a 16-bit upper extension. A 32-bit mode/flag register chooses signed or unsigned operands, integer or fractional format, wrap or clamp on overflow, and truncation or rounding of the fractional product. After every operation it reports the sign, zero, overflow and wide-result state of the result.

Each accumulator has its own sticky overflow bit. The overflow flag visible after an operation is rebuilt from the bit of the accumulator that the operation wrote, so earlier overflows on that accumulator stay visible across later clean operations. Software reaches the mode/flag word, the four low words and the two paired extension words through one register write port and one registered read port.

Top module: `mac4_unit`

## Requirements
- R1: After reset the mode/flag word (select 0) reads 0x0000_0000. Bits 31:12 of it always read zero. A read returns the register chosen by `reg_rsel` on the clock edge after the select is presented.
- R2: In integer mode (bit 5 = 0) the full product of the operands is added (`op_sub`=0) or subtracted (`op_sub`=1) at the destination accumulator. Bit 6 = 1 treats operands and accumulator as unsigned and bit 6 = 0 as two's complement. Without clamping the 48-bit result wraps modulo 2^48.
- R3: In fractional mode (bit 5 = 1) the product is doubled and its low 16 bits are dropped. Bit 4 = 1 rounds by adding 2^15 before the drop, and bit 4 = 0 truncates. Bit 4 has no effect in integer mode.
- R4: An operation overflows when the scaled product, or the exact sum or difference, lies outside the 48-bit range of the selected signedness. Overflow sets sticky bit 8+n for destination n. After every operation, bit 1 equals the sticky bit of the destination.
- R5: A sticky bit clears only when a mode/flag write has bit 1 = 0, which clears all four, or when its accumulator is written directly (low word or extension word). A mode/flag write with bit 1 = 1 keeps all sticky bits.
- R6: With bit 7 = 1, a sum outside the range is clamped instead of wrapping. Signed bounds are 0x7FFF_FFFF_FFFF and 0x8000_0000_0000. Unsigned bounds are 0xFFFF_FFFF_FFFF and 0.
- R7: After each operation, bit 3 is result bit 47 and bit 2 is set when the result is zero. Bit 0 is set when the result does not fit in 32 bits: for signed results, bits 47:31 are not all equal; for unsigned results, bits 47:32 are not all zero.
- R8: Register selects: 0 is the mode/flag word; 1 to 4 are the low 32 bits of accumulators 0 to 3; 5 holds the extension of accumulator 0 in bits 15:0 and of accumulator 1 in bits 31:16; 6 does the same for accumulators 2 and 3; 7 reads zero. A low-word write leaves the extension unchanged, and an extension write leaves the low word unchanged.
- R9: When `reg_wr` and `op_valid` are both high in a cycle, the write is performed and the operation is dropped.
- R10: A mode/flag write loads bits 7:0 from the write data. It never sets a sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform an operation this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 subtracts the product, 0 adds it |
| op_dst | input | 2 | Destination accumulator index |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register written |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 3 | Register read |
| reg_rdata | output | 32 | Registered read data |

## Verification
The hardest state to reach is a sticky overflow bit that is set on one accumulator and survives clean operations on another accumulator. It must then reappear in the overflow flag on the next operation that targets the first accumulator, and clear only through the two permitted paths. The directed test pushes accumulator 2 past its positive bound and runs a clean operation on accumulator 1. It then runs a zero-product operation back on accumulator 2, and follows with a flag write with bit 1 set, a direct load, and a flag write with bit 1 clear. A table of mode combinations is compared against a 48-bit behavioural model, which covers both clamp bounds and rounding.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  // bit positions inside the mode/flag word
  localparam int STAT_EV  = 0;
  localparam int STAT_V   = 1;
  localparam int STAT_Z   = 2;
  localparam int STAT_N   = 3;
  localparam int STAT_RT  = 4;
  localparam int STAT_FI  = 5;
  localparam int STAT_SU  = 6;
  localparam int STAT_OMC = 7;
  localparam int STAT_PAV = 8;

  typedef struct packed {
    logic omc;   // clamp on overflow
    logic su;    // unsigned operands
    logic fi;    // fractional format
    logic rt;    // round fractional product
  } mode_t;
endpackage

// File: rtl/mac4_product.sv
module mac4_product #(
  parameter int OPW  = 32,
  parameter int ACCW = 48,
  localparam int TW  = 2*OPW+4
) (
  input  logic [OPW-1:0]        a_i,
  input  logic [OPW-1:0]        b_i,
  input  logic                  unsigned_i,
  input  logic                  frac_i,
  input  logic                  round_i,
  output logic signed [TW-1:0]  prod_o,
  output logic                  prod_ovf_o
);
  localparam int DROP = 2*OPW-ACCW;
  localparam logic signed [TW-1:0] ZERO = '0;
  localparam logic signed [TW-1:0] RND  = TW'(1) << (DROP-1);
  localparam logic signed [TW-1:0] SMAX = (TW'(1) << (ACCW-1)) - TW'(1);
  localparam logic signed [TW-1:0] SMIN = -(TW'(1) << (ACCW-1));
  localparam logic signed [TW-1:0] UMAX = (TW'(1) << ACCW) - TW'(1);

  logic signed [OPW:0]      ax, bx;
  logic signed [2*OPW+1:0]  full;
  logic signed [TW-1:0]     wide, dbl, hi, lo;

  always_comb begin
    ax   = {(~unsigned_i & a_i[OPW-1]), a_i};
    bx   = {(~unsigned_i & b_i[OPW-1]), b_i};
    full = ax * bx;
    wide = {{(TW-2*OPW-2){full[2*OPW+1]}}, full};
    dbl  = (wide <<< 1) + (round_i ? RND : ZERO);
    prod_o = frac_i ? (dbl >>> DROP) : wide;
    hi = unsigned_i ? UMAX : SMAX;
    lo = unsigned_i ? ZERO : SMIN;
    prod_ovf_o = (prod_o > hi) || (prod_o < lo);
  end
endmodule

// File: rtl/mac4_accum.sv
module mac4_accum #(
  parameter int OPW  = 32,
  parameter int ACCW = 48,
  localparam int TW  = 2*OPW+4
) (
  input  logic [ACCW-1:0]       acc_i,
  input  logic signed [TW-1:0]  prod_i,
  input  logic                  prod_ovf_i,
  input  logic                  sub_i,
  input  logic                  unsigned_i,
  input  logic                  sat_i,
  output logic [ACCW-1:0]       res_o,
  output logic                  ovf_o,
  output logic                  sum_ovf_o,
  output logic                  n_o,
  output logic                  z_o,
  output logic                  ev_o
);
  localparam logic signed [TW-1:0] ZERO = '0;
  localparam logic signed [TW-1:0] SMAX = (TW'(1) << (ACCW-1)) - TW'(1);
  localparam logic signed [TW-1:0] SMIN = -(TW'(1) << (ACCW-1));
  localparam logic signed [TW-1:0] UMAX = (TW'(1) << ACCW) - TW'(1);

  logic signed [TW-1:0] accx, tsum, hi, lo;
  logic                 above, below;
  logic [ACCW-OPW:0]    top;

  always_comb begin
    accx  = {{(TW-ACCW){~unsigned_i & acc_i[ACCW-1]}}, acc_i};
    tsum  = sub_i ? (accx - prod_i) : (accx + prod_i);
    hi    = unsigned_i ? UMAX : SMAX;
    lo    = unsigned_i ? ZERO : SMIN;
    above = tsum > hi;
    below = tsum < lo;
    if (sat_i && above)      res_o = hi[ACCW-1:0];
    else if (sat_i && below) res_o = lo[ACCW-1:0];
    else                     res_o = tsum[ACCW-1:0];
    sum_ovf_o = above | below;
    ovf_o     = prod_ovf_i | above | below;
    n_o       = res_o[ACCW-1];
    z_o       = (res_o == '0);
    top       = res_o[ACCW-1:OPW-1];
    ev_o      = unsigned_i ? (|res_o[ACCW-1:OPW]) : !((&top) || !(|top));
  end
endmodule

// File: rtl/mac4_unit.sv
module mac4_unit
  import mac4_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int ACCW  = 48,
  parameter int NACC  = 4,
  localparam int NPAIR = NACC/2,
  localparam int NREG  = 1+NACC+NPAIR,
  localparam int SELW  = $clog2(NREG+1),
  localparam int IDXW  = $clog2(NACC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  logic             op_sub,
  input  logic [IDXW-1:0]  op_dst,
  input  logic             reg_wr,
  input  logic [SELW-1:0]  reg_sel,
  input  logic [OPW-1:0]   reg_wdata,
  input  logic [SELW-1:0]  reg_rsel,
  output logic [OPW-1:0]   reg_rdata
);
  localparam int EXTW = ACCW-OPW;
  localparam int TW   = 2*OPW+4;

  mode_t             mode_q;
  logic              n_q, z_q, v_q, ev_q;
  logic [NACC-1:0]   pav_q;
  logic [ACCW-1:0]   acc_q [NACC];

  logic              op_go, wr_status;
  logic [NACC-1:0]   wr_main, wr_ext;
  logic [ACCW-1:0]   acc_cur, res_w;
  logic signed [TW-1:0] prod_w;
  logic              prod_ovf_w, ovf_w, sum_ovf_w, n_w, z_w, ev_w;
  logic [OPW-1:0]    stat_word, rd_word;

  // a register write takes the cycle; a colliding operation is dropped (R9)
  assign op_go     = op_valid & ~reg_wr;
  assign wr_status = reg_wr && (reg_sel == '0);
  assign acc_cur   = acc_q[op_dst];

  always_comb begin
    for (int n = 0; n < NACC; n++) begin
      wr_main[n] = reg_wr && (reg_sel == SELW'(1+n));
      wr_ext[n]  = reg_wr && (reg_sel == SELW'(1+NACC+n/2));
    end
  end

  mac4_product #(.OPW(OPW), .ACCW(ACCW)) u_product (
    .a_i(op_a), .b_i(op_b),
    .unsigned_i(mode_q.su), .frac_i(mode_q.fi), .round_i(mode_q.rt),
    .prod_o(prod_w), .prod_ovf_o(prod_ovf_w)
  );

  mac4_accum #(.OPW(OPW), .ACCW(ACCW)) u_accum (
    .acc_i(acc_cur), .prod_i(prod_w), .prod_ovf_i(prod_ovf_w),
    .sub_i(op_sub), .unsigned_i(mode_q.su), .sat_i(mode_q.omc),
    .res_o(res_w), .ovf_o(ovf_w), .sum_ovf_o(sum_ovf_w),
    .n_o(n_w), .z_o(z_w), .ev_o(ev_w)
  );

  // accumulator storage: contents undefined until loaded, so no reset
  always_ff @(posedge clk) begin
    for (int n = 0; n < NACC; n++) begin
      if (wr_main[n])
        acc_q[n][OPW-1:0] <= reg_wdata;
      else if (wr_ext[n])
        acc_q[n][ACCW-1:OPW] <= reg_wdata[(n%2)*EXTW +: EXTW];
      else if (op_go && (op_dst == IDXW'(n)))
        acc_q[n] <= res_w;
    end
  end

  // sticky per-accumulator overflow bits (R4, R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      pav_q <= '0;
    end else begin
      for (int n = 0; n < NACC; n++) begin
        if (wr_main[n] || wr_ext[n])
          pav_q[n] <= 1'b0;
        else if (wr_status && !reg_wdata[STAT_V])
          pav_q[n] <= 1'b0;
        else if (op_go && (op_dst == IDXW'(n)) && ovf_w)
          pav_q[n] <= 1'b1;
      end
    end
  end

  // mode bits and condition flags
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      n_q <= 1'b0; z_q <= 1'b0; v_q <= 1'b0; ev_q <= 1'b0;
    end else if (wr_status) begin
      mode_q <= reg_wdata[STAT_RT +: 4];
      n_q    <= reg_wdata[STAT_N];
      z_q    <= reg_wdata[STAT_Z];
      v_q    <= reg_wdata[STAT_V];
      ev_q   <= reg_wdata[STAT_EV];
    end else if (op_go) begin
      n_q  <= n_w;
      z_q  <= z_w;
      ev_q <= ev_w;
      v_q  <= pav_q[op_dst] | ovf_w;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_PAV +: NACC] = pav_q;
    stat_word[STAT_RT +: 4]     = mode_q;
    stat_word[STAT_N]  = n_q;
    stat_word[STAT_Z]  = z_q;
    stat_word[STAT_V]  = v_q;
    stat_word[STAT_EV] = ev_q;
  end

  always_comb begin
    rd_word = '0;
    if (reg_rsel == '0) rd_word = stat_word;
    for (int n = 0; n < NACC; n++)
      if (reg_rsel == SELW'(1+n)) rd_word = acc_q[n][OPW-1:0];
    for (int p = 0; p < NPAIR; p++)
      if (reg_rsel == SELW'(1+NACC+p))
        rd_word[2*EXTW-1:0] = {acc_q[2*p+1][ACCW-1:OPW], acc_q[2*p][ACCW-1:OPW]};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_word;
  end

  // ---------------- assertions ----------------
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_rsel) == '0) |-> (reg_rdata[OPW-1:STAT_PAV+NACC] == '0));

  assert_v_follows_pav_R4: assert property (@(posedge clk) disable iff (rst)
    $past(op_go) |-> (v_q == pav_q[$past(op_dst)]));

  assert_pav_clears_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    (|($past(pav_q) & ~pav_q)) |-> $past(reg_wr));

  assert_clamp_signed_R6: assert property (@(posedge clk) disable iff (rst)
    $past(op_go && mode_q.omc && !mode_q.su && sum_ovf_w) |->
      ((acc_q[$past(op_dst)] == {1'b0, {(ACCW-1){1'b1}}}) ||
       (acc_q[$past(op_dst)] == {1'b1, {(ACCW-1){1'b0}}})));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $past(op_go) |-> (z_q == (acc_q[$past(op_dst)] == '0)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && op_valid && !wr_status) |-> $stable(n_q));
endmodule

// File: tb/test_mac4_unit.sv
module test_mac4_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic [1:0]  op_dst = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_rsel = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac4_unit i_mac4_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .op_dst(op_dst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata)
  );

  // mode nibble order: {clamp, unsigned, fractional, round}
  typedef struct packed {
    logic [3:0]  mode;
    logic [47:0] acc;
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic [1:0]  dst;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{4'b0000, 48'h0,            32'd3,        32'd5,        1'b0, 2'd0},
    '{4'b0000, 48'd10,           32'hFFFFFFFE, 32'd7,        1'b1, 2'd1},
    '{4'b0100, 48'h0,            32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 2'd2},
    '{4'b1000, 48'h7FFFFFFFFFF0, 32'd16,       32'd1,        1'b0, 2'd3},
    '{4'b1000, 48'h800000000005, 32'd6,        32'd1,        1'b1, 2'd0},
    '{4'b0000, 48'h7FFFFFFFFFF0, 32'd16,       32'd1,        1'b0, 2'd1},
    '{4'b0010, 48'h0,            32'h40000000, 32'h40000000, 1'b0, 2'd2},
    '{4'b0011, 48'h0,            32'd1,        32'h00004000, 1'b0, 2'd3},
    '{4'b0010, 48'h0,            32'd1,        32'h00004000, 1'b0, 2'd0},
    '{4'b1010, 48'h0,            32'h80000000, 32'h80000000, 1'b0, 2'd1},
    '{4'b1100, 48'd5,            32'd6,        32'd1,        1'b1, 2'd2},
    '{4'b0000, 48'h0,            32'h00010000, 32'h00010000, 1'b0, 2'd3},
    '{4'b0111, 48'h000000001234, 32'h80000000, 32'h0000C000, 1'b0, 2'd0},
    '{4'b1000, 48'hFFFFFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b0, 2'd2},
    '{4'b0001, 48'h0,            32'd7,        32'd9,        1'b0, 2'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_rsel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [1:0] dst);
    @(negedge clk);
    op_valid = 1'b1; op_a = a; op_b = b; op_sub = sub; op_dst = dst;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load_acc(input int n, input logic [47:0] v);
    logic [31:0] e;
    wr(3'(1+n), v[31:0]);
    rd(3'(5+n/2), e);
    if (n % 2 == 1) e[31:16] = v[47:32];
    else            e[15:0]  = v[47:32];
    wr(3'(5+n/2), e);
  endtask

  task automatic rd_acc(input int n, output logic [47:0] v);
    logic [31:0] lo, e;
    rd(3'(1+n), lo);
    rd(3'(5+n/2), e);
    v = {(n % 2 == 1) ? e[31:16] : e[15:0], lo};
  endtask

  // behavioural model: returns {overflow, result}
  function automatic logic [48:0] ref_mac(input logic [3:0] mode, input logic [47:0] acc,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic sub);
    logic signed [67:0] ax, bx, p, accx, t, hi, lo;
    logic omc, su, fi, rt, pov, tov;
    logic [47:0] res;
    {omc, su, fi, rt} = mode;
    ax = su ? {36'b0, a} : {{36{a[31]}}, a};
    bx = su ? {36'b0, b} : {{36{b[31]}}, b};
    p  = ax * bx;
    if (fi) p = (p * 2 + (rt ? 68'sd32768 : 68'sd0)) >>> 16;
    hi = su ? ((68'sd1 <<< 48) - 1) : ((68'sd1 <<< 47) - 1);
    lo = su ? 68'sd0 : -(68'sd1 <<< 47);
    pov  = (p > hi) || (p < lo);
    accx = su ? {20'b0, acc} : {{20{acc[47]}}, acc};
    t    = sub ? accx - p : accx + p;
    tov  = (t > hi) || (t < lo);
    if (omc && t > hi)      res = hi[47:0];
    else if (omc && t < lo) res = lo[47:0];
    else                    res = t[47:0];
    return {pov | tov, res};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [47:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset value of mode/flag word; R8: unused select reads zero
    rd(3'd0, d); chk("R1 reset status", 64'(d), 64'h0);
    rd(3'd7, d); chk("R8 unused select", 64'(d), 64'h0);

    // R1/R10: reserved bits read zero, bits 7:0 loaded, no sticky bit set
    wr(3'd0, 32'hFFFF_FFFD);
    rd(3'd0, d); chk("R10 status write", 64'(d), 64'h0000_00FD);
    wr(3'd0, 32'h0);

    // table walk against the model (R2, R3, R6, R7, R4)
    for (int i = 0; i < NVEC; i++) begin
      logic [48:0] e;
      logic [47:0] r;
      logic [31:0] st, est;
      string tag;
      wr(3'd0, {24'b0, VEC[i].mode, 4'b0});
      load_acc(int'(VEC[i].dst), VEC[i].acc);
      do_op(VEC[i].a, VEC[i].b, VEC[i].sub, VEC[i].dst);
      rd_acc(int'(VEC[i].dst), r);
      e = ref_mac(VEC[i].mode, VEC[i].acc, VEC[i].a, VEC[i].b, VEC[i].sub);
      if (VEC[i].mode[1])      tag = "R3 fractional result";
      else if (VEC[i].mode[3]) tag = "R6 clamped result";
      else                     tag = "R2 integer result";
      chk($sformatf("%s vec %0d", tag, i), 64'(r), 64'(e[47:0]));
      est = '0;
      est[8 + VEC[i].dst] = e[48];
      est[7:4] = VEC[i].mode;
      est[3] = e[47];
      est[2] = (e[47:0] == '0);
      est[1] = e[48];
      est[0] = VEC[i].mode[2] ? (|e[47:32]) : !((&e[47:31]) || !(|e[47:31]));
      rd(3'd0, st);
      chk($sformatf("R7 R4 flags vec %0d", i), 64'(st), 64'(est));
    end

    // sticky overflow sequence (R4, R5)
    wr(3'd0, 32'h0);
    load_acc(2, 48'h7FFF_FFFF_FFFF);
    do_op(32'd1, 32'd1, 1'b0, 2'd2);
    load_acc(1, 48'h0);
    do_op(32'd1, 32'd1, 1'b0, 2'd1);
    rd(3'd0, d); chk("R4 V from clean dst, PAV2 kept", 64'(d), 64'h400);
    do_op(32'd0, 32'd0, 1'b0, 2'd2);
    rd(3'd0, d); chk("R4 V rebuilt from PAV2", 64'(d), 64'h40B);
    wr(3'd0, 32'h0000_0002);
    rd(3'd0, d); chk("R5 status write V=1 keeps sticky", 64'(d), 64'h402);
    wr(3'd3, 32'h0);
    rd(3'd0, d); chk("R5 direct load clears PAV2", 64'(d), 64'h002);
    load_acc(3, 48'h7FFF_FFFF_FFFF);
    do_op(32'd1, 32'd1, 1'b0, 2'd3);
    rd(3'd0, d); chk("R4 PAV3 set", 64'(d), 64'h80B);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R5 status write V=0 clears sticky", 64'(d), 64'h000);

    // collision: write wins, operation dropped (R9)
    load_acc(0, 48'd100);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'hABCD_0123;
    op_valid = 1'b1; op_a = 32'd1; op_b = 32'd1; op_sub = 1'b0; op_dst = 2'd0;
    @(negedge clk);
    reg_wr = 1'b0; op_valid = 1'b0;
    rd_acc(0, v); chk("R9 dropped op leaves ACC0", 64'(v), 64'd100);
    rd(3'd4, d);  chk("R9 colliding write done", 64'(d), 64'hABCD_0123);

    // extension pair layout (R8)
    wr(3'd5, 32'h1111_2222);
    rd(3'd5, d); chk("R8 extension pair readback", 64'(d), 64'h1111_2222);
    rd_acc(0, v); chk("R8 ACC0 ext low half, low word kept", 64'(v), 64'h2222_0000_0064);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule